// File: doc/BRIEF.md
# Two-Level Priority Round-Robin Router Output Port

This block is the egress side of one direction of a five-direction wormhole router. Every input buffer that holds a flit for this direction raises a request on one of two lanes. The urgent lane carries signaling traffic. The normal lane carries read/write traffic. With each request the input also presents the flit at the head of its buffer. Each cycle the port picks at most one flit, registers it onto the downstream link and pulses a read strobe back to the buffer that supplied it. The strobe pops that flit.

Inside a lane, the inputs take turns in round-robin order. Once a multi-flit packet starts, the lane stays on that input until the packet's last flit has left. Between lanes the urgent one always wins when it can send. An urgent flit may therefore slip between two flits of a normal-lane packet, and the normal packet carries on afterwards from the same input. Each lane has its own downstream "no room" signal. A blocked lane never sends, and it never holds back the other lane.

Top module: `prio_rr_outport`

## Requirements
- R1: While reset is asserted the output flit type is idle (00), and reset clears any packet lock and sets both round-robin pointers to input 0.
- R2: Flit type sits in the two most significant bits: 00 idle, 01 body, 10 end of packet, 11 single-flit packet. The flit read by a strobe appears on `out_flit` after the next rising edge, and `out_urgent` is 1 for the urgent lane and 0 otherwise.
- R3: Single-flit packets that several inputs present together on one lane go out one per grant. The search starts at the input after the one that last finished a packet, and wraps from input 4 to input 0.
- R4: When the urgent lane has a requesting flit and room downstream, the normal lane is not read in that cycle.
- R5: An urgent flit may be sent between two flits of a normal-lane packet. The normal packet then continues from the same input.
- R6: After a body flit is granted, its lane grants only that input until the matching end flit is sent. If that input does not request, the lane sends nothing.
- R7: A lane's round-robin pointer moves only when an end or single flit is granted, and then it moves to the input after the granted one.
- R8: A lane whose downstream full signal is high in a cycle is not read in that cycle. The other lane may send in that same cycle.
- R9: A new flit can be sent in every cycle, with no empty cycle when the grant moves to another input or to the other lane.
- R10: In a cycle with no read strobe, the next output flit is all zeros (type 00) and `out_urgent` is 0.
- R11: At most one read strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_urg | input | N_IN | Urgent-lane request, one bit per input |
| req_nrm | input | N_IN | Normal-lane request, one bit per input |
| flit_urg | input | N_IN*FLIT_W | Urgent-lane head flits, input i at bits [i*FLIT_W +: FLIT_W] |
| flit_nrm | input | N_IN*FLIT_W | Normal-lane head flits, same packing |
| full_urg | input | 1 | Downstream urgent buffer has no room |
| full_nrm | input | 1 | Downstream normal buffer has no room |
| rd_urg | output | N_IN | Read strobe to each input's urgent buffer |
| rd_nrm | output | N_IN | Read strobe to each input's normal buffer |
| out_flit | output | FLIT_W | Registered outgoing flit |
| out_urgent | output | 1 | Registered lane of the outgoing flit |

## Verification
The bench builds the port with its default parameters: five inputs and 16-bit flits. With five inputs the round-robin search can wrap from input 4 back to input 0. It also allows a locked input, a different waiting input and a pointer position that disagree, which lets the test show whether a choice came from the lock, from the pointer, or from plain lowest-index order. The step table covers these cases on both lanes: a lane preempted in the middle of a packet, a full downstream buffer on each lane with the other lane still sending, and a reset that lands inside a packet.

// File: rtl/prio_out_pkg.sv
package prio_out_pkg;

    typedef enum logic [1:0] {
        FT_IDLE   = 2'b00,
        FT_BODY   = 2'b01,
        FT_END    = 2'b10,
        FT_SINGLE = 2'b11
    } ftype_e;

    localparam int NUM_LANES = 2;
    localparam int LANE_NRM  = 0;
    localparam int LANE_URG  = 1;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N_IN = 5,
    parameter int IW   = 3
) (
    input  logic [N_IN-1:0] req,
    input  logic [IW-1:0]   start,
    output logic [IW-1:0]   idx,
    output logic            any
);

    always_comb begin
        int j;
        any = 1'b0;
        idx = '0;
        for (int k = N_IN - 1; k >= 0; k--) begin
            j = (int'(start) + k) % N_IN;
            if (req[j]) begin
                any = 1'b1;
                idx = IW'(j);
            end
        end
    end

endmodule

// File: rtl/lane_arb.sv
module lane_arb
    import prio_out_pkg::*;
#(
    parameter int N_IN = 5,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req,
    input  logic            full,
    input  logic            take,
    input  ftype_e          gtype,
    output logic [IW-1:0]   cand,
    output logic            ready
);

    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic [IW-1:0] rr_idx;
    logic          rr_any;

    rr_pick #(.N_IN(N_IN), .IW(IW)) i_rr_pick (
        .req   (req),
        .start (st_q.ptr),
        .idx   (rr_idx),
        .any   (rr_any)
    );

    always_comb begin
        st_d  = st_q;
        cand  = st_q.locked ? st_q.owner : rr_idx;
        ready = !full && (st_q.locked ? req[st_q.owner] : rr_any);
        if (take) begin
            if (gtype == FT_BODY) begin
                st_d.locked = 1'b1;
                st_d.owner  = cand;
            end else begin
                st_d.locked = 1'b0;
                st_d.ptr    = (int'(cand) == N_IN - 1) ? '0 : cand + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.ptr)); // R7

    AST_HOLD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && gtype == FT_BODY) |=> (!take || cand == $past(cand))); // R6

endmodule

// File: rtl/prio_rr_outport.sv
module prio_rr_outport
    import prio_out_pkg::*;
#(
    parameter int N_IN   = 5,
    parameter int FLIT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        req_urg,
    input  logic [N_IN-1:0]        req_nrm,
    input  logic [N_IN*FLIT_W-1:0] flit_urg,
    input  logic [N_IN*FLIT_W-1:0] flit_nrm,
    input  logic                   full_urg,
    input  logic                   full_nrm,
    output logic [N_IN-1:0]        rd_urg,
    output logic [N_IN-1:0]        rd_nrm,
    output logic [FLIT_W-1:0]      out_flit,
    output logic                   out_urgent
);

    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    typedef struct packed {
        logic              urgent;
        logic [FLIT_W-1:0] flit;
    } out_st_t;

    logic [NUM_LANES-1:0][N_IN-1:0]        lane_req;
    logic [NUM_LANES-1:0][N_IN*FLIT_W-1:0] lane_flits;
    logic [NUM_LANES-1:0]                  lane_full;
    logic [NUM_LANES-1:0]                  lane_rdy;
    logic [NUM_LANES-1:0]                  lane_take;
    logic [NUM_LANES-1:0][IW-1:0]          lane_cand;
    logic [NUM_LANES-1:0][FLIT_W-1:0]      lane_head;
    ftype_e                                lane_type [NUM_LANES];

    out_st_t out_d, out_q;

    assign lane_req   = {req_urg, req_nrm};
    assign lane_flits = {flit_urg, flit_nrm};
    assign lane_full  = {full_urg, full_nrm};

    // urgent lane wins whenever it is able to send
    assign lane_take[LANE_URG] = lane_rdy[LANE_URG];
    assign lane_take[LANE_NRM] = lane_rdy[LANE_NRM] && !lane_rdy[LANE_URG];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_head[g] = lane_flits[g][int'(lane_cand[g]) * FLIT_W +: FLIT_W];
        assign lane_type[g] = ftype_e'(lane_head[g][FLIT_W-1 -: 2]);

        lane_arb #(.N_IN(N_IN), .IW(IW)) i_lane_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (lane_req[g]),
            .full  (lane_full[g]),
            .take  (lane_take[g]),
            .gtype (lane_type[g]),
            .cand  (lane_cand[g]),
            .ready (lane_rdy[g])
        );
    end

    assign rd_urg = lane_take[LANE_URG] ? (N_IN'(1) << lane_cand[LANE_URG]) : '0;
    assign rd_nrm = lane_take[LANE_NRM] ? (N_IN'(1) << lane_cand[LANE_NRM]) : '0;

    always_comb begin
        out_d = '0;
        if (lane_take[LANE_URG]) begin
            out_d.urgent = 1'b1;
            out_d.flit   = lane_head[LANE_URG];
        end else if (lane_take[LANE_NRM]) begin
            out_d.flit   = lane_head[LANE_NRM];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_flit   = out_q.flit;
    assign out_urgent = out_q.urgent;

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_urg, rd_nrm})); // R11

    AST_NO_SEND_FULL_URG: assert property (@(posedge clk) disable iff (!rst_n)
        full_urg |-> (rd_urg == '0)); // R8

    AST_NO_SEND_FULL_NRM: assert property (@(posedge clk) disable iff (!rst_n)
        full_nrm |-> (rd_nrm == '0)); // R8

    AST_URG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        lane_rdy[LANE_URG] |-> (rd_nrm == '0)); // R4

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_urg == '0 && rd_nrm == '0) |=> (out_flit[FLIT_W-1 -: 2] == 2'b00 && !out_urgent)); // R10

    AST_LANE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_urg != '0) |=> out_urgent); // R2

endmodule

// File: tb/test_prio_rr_outport.sv
module test_prio_rr_outport;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 5;
    localparam int W   = 16;
    localparam int NV  = 21;

    typedef struct packed {
        logic [4:0] ru;
        logic [4:0] rn;
        logic [1:0] tu;
        logic [1:0] tn;
        logic       fu;
        logic       fn;
        logic [4:0] eu;
        logic [4:0] en;
        logic [7:0] rq;
    } vec_t;

    // ru, rn, type urg, type nrm, full urg, full nrm, expected rd_urg, expected rd_nrm, requirement
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 5'b00000, 2'b00, 2'b00, 1'b0, 1'b0, 5'b00000, 5'b00000, 8'd10}, // R10 nothing requested
        '{5'b00000, 5'b10110, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b00010, 8'd3},  // R3 start after ptr 0
        '{5'b00000, 5'b10100, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b00100, 8'd3},  // R3
        '{5'b00000, 5'b10011, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b10000, 8'd3},  // R3 skips 0,1 from ptr 3
        '{5'b00000, 5'b00011, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b00001, 8'd3},  // R3 wrap to 0
        '{5'b01000, 5'b00010, 2'b11, 2'b11, 1'b0, 1'b0, 5'b01000, 5'b00000, 8'd4},  // R4 urgent first
        '{5'b00000, 5'b00010, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b00010, 8'd9},  // R9 lane switch, no gap
        '{5'b00000, 5'b00101, 2'b00, 2'b01, 1'b0, 1'b0, 5'b00000, 5'b00100, 8'd6},  // R6 body locks input 2
        '{5'b00001, 5'b00101, 2'b11, 2'b01, 1'b0, 1'b0, 5'b00001, 5'b00000, 8'd5},  // R5 preempt mid packet
        '{5'b00000, 5'b00101, 2'b00, 2'b01, 1'b0, 1'b0, 5'b00000, 5'b00100, 8'd5},  // R5 resumes input 2
        '{5'b00000, 5'b00001, 2'b00, 2'b01, 1'b0, 1'b0, 5'b00000, 5'b00000, 8'd6},  // R6 owner silent
        '{5'b00000, 5'b00101, 2'b00, 2'b10, 1'b0, 1'b0, 5'b00000, 5'b00100, 8'd6},  // R6 end from owner
        '{5'b00000, 5'b00101, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b00001, 8'd7},  // R7 ptr now 3
        '{5'b00010, 5'b00100, 2'b11, 2'b11, 1'b1, 1'b0, 5'b00000, 5'b00100, 8'd8},  // R8 urgent full
        '{5'b00010, 5'b01000, 2'b11, 2'b11, 1'b0, 1'b1, 5'b00010, 5'b00000, 8'd8},  // R8 normal full
        '{5'b00000, 5'b01000, 2'b00, 2'b11, 1'b0, 1'b1, 5'b00000, 5'b00000, 8'd8},  // R8 only normal, full
        '{5'b00000, 5'b01000, 2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 5'b01000, 8'd8},  // R8 room again
        '{5'b00011, 5'b00000, 2'b01, 2'b00, 1'b0, 1'b0, 5'b00001, 5'b00000, 8'd6},  // R6 urgent body, ptr 2 wraps
        '{5'b00011, 5'b00000, 2'b10, 2'b00, 1'b0, 1'b0, 5'b00001, 5'b00000, 8'd6},  // R6 urgent end
        '{5'b00011, 5'b00000, 2'b11, 2'b00, 1'b0, 1'b0, 5'b00010, 5'b00000, 8'd7},  // R7 urgent ptr 1
        '{5'b00000, 5'b00000, 2'b00, 2'b00, 1'b0, 1'b0, 5'b00000, 5'b00000, 8'd10}  // R10
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_urg = '0, req_nrm = '0;
    logic [N*W-1:0] flit_urg = '0, flit_nrm = '0;
    logic           full_urg = 1'b0, full_nrm = 1'b0;
    logic [N-1:0]   rd_urg, rd_nrm;
    logic [W-1:0]   out_flit;
    logic           out_urgent;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_rr_outport #(.N_IN(N), .FLIT_W(W)) i_prio_rr_outport (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_urg    (req_urg),
        .req_nrm    (req_nrm),
        .flit_urg   (flit_urg),
        .flit_nrm   (flit_nrm),
        .full_urg   (full_urg),
        .full_nrm   (full_nrm),
        .rd_urg     (rd_urg),
        .rd_nrm     (rd_nrm),
        .out_flit   (out_flit),
        .out_urgent (out_urgent)
    );

    function automatic logic [W-1:0] mk(input int lane, input int idx, input logic [1:0] ty);
        return {ty, 14'(lane * 16 + idx + 1)};
    endfunction

    function automatic int first_one(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic drive(input logic [N-1:0] ru, input logic [N-1:0] rn,
                         input logic [1:0] tu, input logic [1:0] tn,
                         input logic fu, input logic fn);
        req_urg  = ru;
        req_nrm  = rn;
        full_urg = fu;
        full_nrm = fn;
        for (int i = 0; i < N; i++) begin
            flit_urg[i*W +: W] = mk(1, i, tu);
            flit_nrm[i*W +: W] = mk(0, i, tn);
        end
    endtask

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W:0] exp_out;
        drive('0, '0, 2'b00, 2'b00, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        // R1: idle output while in reset
        chk(out_flit[W-1 -: 2] == 2'b00 && !out_urgent, 1, "reset output",
            {15'd0, out_urgent, out_flit}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < NV; s++) begin
            @(negedge clk);
            drive(VEC[s].ru, VEC[s].rn, VEC[s].tu, VEC[s].tn, VEC[s].fu, VEC[s].fn);
            #1;
            chk({rd_urg, rd_nrm} == {VEC[s].eu, VEC[s].en}, int'(VEC[s].rq), $sformatf("step %0d strobes", s),
                {22'd0, rd_urg, rd_nrm}, {22'd0, VEC[s].eu, VEC[s].en});
            if (VEC[s].eu != '0)
                exp_out = {1'b1, mk(1, first_one(VEC[s].eu), VEC[s].tu)};
            else if (VEC[s].en != '0)
                exp_out = {1'b0, mk(0, first_one(VEC[s].en), VEC[s].tn)};
            else
                exp_out = '0;
            @(posedge clk);
            #1;
            // R2: registered flit and lane tag
            chk({out_urgent, out_flit} == exp_out, int'(VEC[s].rq), $sformatf("step %0d output", s),
                {15'd0, out_urgent, out_flit}, {15'd0, exp_out});
        end

        // R1: reset inside a packet drops the lock and pointer
        @(negedge clk);
        drive('0, 5'b01000, 2'b00, 2'b01, 1'b0, 1'b0);   // body from input 3 (pointer at 4 -> picks 3)
        #1;
        chk(rd_nrm == 5'b01000, 1, "lock set before reset", {27'd0, rd_nrm}, 32'h08);
        @(negedge clk);
        rst_n = 1'b0;
        drive('0, '0, 2'b00, 2'b00, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        chk(out_flit == '0, 1, "output cleared by reset", {16'd0, out_flit}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive('0, 5'b01001, 2'b00, 2'b11, 1'b0, 1'b0);
        #1;
        chk(rd_nrm == 5'b00001, 1, "after reset picks input 0", {27'd0, rd_nrm}, 32'h01);

        // R9: back-to-back flits from two inputs with no gap
        @(posedge clk);
        #1;
        chk(out_flit == mk(0, 0, 2'b11), 9, "first of pair", {16'd0, out_flit}, {16'd0, mk(0, 0, 2'b11)});
        @(negedge clk);
        drive('0, 5'b01000, 2'b00, 2'b11, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        chk(out_flit == mk(0, 3, 2'b11), 9, "second of pair", {16'd0, out_flit}, {16'd0, mk(0, 3, 2'b11)});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule